// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This unit sits next to a 16-bit processor and watches two address streams: the instruction-fetch address and the data-memory address with its read and write strobes. Two programmable address registers serve either as two independent match points or as the low and high ends of one inclusive window. When a qualified access matches and breaking is enabled, the unit raises a halt request in the same cycle. It also records the cause in sticky status flags.

A debug host programs the unit through a four-entry register port. Register index 0 holds control, index 1 holds status, index 2 holds the first address and index 3 the second. Status flags are cleared by writing ones to them. A pending-break output stays high while any flag is set, which lets the host see that the core stopped on a breakpoint.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset all four registers read as zero, and halt_req and brk_pending are low.
- R2: Control (index 0) holds an access mode in bits 1:0 (01 read, 10 write, 11 either, 00 none), break enable in bit 2, fetch matching in bit 3 and window mode in bit 4. A read of control returns bits 4:0, with the upper bits zero. Indices 2 and 3 read back the full 16-bit address written.
- R3: In point mode (bit 4 clear), a data read at address 0 sets status bit 0, a data write at address 0 sets bit 1, a data read at address 1 sets bit 2, and a data write at address 1 sets bit 3. A read sets a flag only when mode bit 0 is set; a write sets a flag only when mode bit 1 is set.
- R4: When bit 3 is set, an instruction fetch counts as a read: a fetch at address 0 sets bit 0 and a fetch at address 1 sets bit 2. When bit 3 is clear, fetches have no effect.
- R5: With access mode 00, no access of any kind sets a flag or raises halt_req.
- R6: In window mode, a qualified read with address0 <= addr <= address1 (unsigned) sets bit 4, and a qualified write in that window sets bit 5. Bits 3:0 are not set in window mode.
- R7: In window mode with address0 > address1, nothing matches.
- R8: halt_req is high in the same cycle as a qualified matching access when break enable is set. With break enable clear, no flag is set and halt_req stays low.
- R9: Writing to status clears each flag whose bit is 1 in the written data and leaves flags written with 0 unchanged. A flag set by a hit in the same cycle as a clear stays set.
- R10: brk_pending is high exactly while any status flag is set.
- R11: A read of status returns the flags in bits 5:0, with bits 15:6 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 2 | Register index: 0 control, 1 status, 2 address 0, 3 address 1 |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_idx (combinational) |
| fetch_vld | input | 1 | Instruction fetch in this cycle |
| fetch_addr | input | 16 | Instruction fetch address |
| dmem_addr | input | 16 | Data-memory address |
| dmem_rd | input | 1 | Data read strobe |
| dmem_wr | input | 1 | Data write strobe |
| halt_req | output | 1 | Halt request to the core, same cycle as the hit |
| brk_pending | output | 1 | High while any status flag is set |

## Verification
The hardest cases to reach are the ones where several control fields combine. Examples are a fetch that only counts when both fetch matching and read mode are set, a window whose bounds are inverted, and accesses that land exactly on a window edge or one address outside it. The bench sweeps all 32 control values against fetch, read and write accesses at five addresses around both match points. It runs this sweep once with an ordered window and once with an inverted one, and computes each expected flag set from the field rules. Directed steps then cover partial write-one-to-clear and a clear that collides with a new hit.

// File: rtl/addr_watch_unit.sv
module addr_watch_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_idx,
  input  logic         reg_wen,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         fetch_vld,
  input  logic [W-1:0] fetch_addr,
  input  logic [W-1:0] dmem_addr,
  input  logic         dmem_rd,
  input  logic         dmem_wr,
  output logic         halt_req,
  output logic         brk_pending
);
  localparam int CW = 5;
  localparam int SW = 6;
  localparam logic [1:0] IX_CTL = 2'd0, IX_STS = 2'd1, IX_A0 = 2'd2, IX_A1 = 2'd3;

  logic [CW-1:0] ctl_q;
  logic [SW-1:0] sts_q;
  logic [W-1:0]  a0_q, a1_q;

  wire rd_ok   = ctl_q[0];
  wire wr_ok   = ctl_q[1];
  wire brk_en  = ctl_q[2];
  wire fch_en  = ctl_q[3];
  wire win_mod = ctl_q[4];

  wire f_rd = fetch_vld & fch_en & rd_ok;
  wire d_rd = dmem_rd & rd_ok;
  wire d_wr = dmem_wr & wr_ok;

  wire f_m0 = fetch_addr == a0_q;
  wire f_m1 = fetch_addr == a1_q;
  wire d_m0 = dmem_addr == a0_q;
  wire d_m1 = dmem_addr == a1_q;
  wire f_in = (fetch_addr >= a0_q) && (fetch_addr <= a1_q);
  wire d_in = (dmem_addr >= a0_q) && (dmem_addr <= a1_q);

  logic [SW-1:0] hit;
  always_comb begin
    hit = '0;
    if (!win_mod) begin
      hit[0] = (f_rd & f_m0) | (d_rd & d_m0);
      hit[1] = d_wr & d_m0;
      hit[2] = (f_rd & f_m1) | (d_rd & d_m1);
      hit[3] = d_wr & d_m1;
    end else begin
      hit[4] = (f_rd & f_in) | (d_rd & d_in);
      hit[5] = d_wr & d_in;
    end
    if (!brk_en) hit = '0;
  end

  wire           sts_wr = reg_wen && reg_idx == IX_STS;
  wire [SW-1:0]  clr    = sts_wr ? reg_wdata[SW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sts_q <= '0;
      a0_q  <= '0;
      a1_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | hit;
      if (reg_wen && reg_idx == IX_CTL) ctl_q <= reg_wdata[CW-1:0];
      if (reg_wen && reg_idx == IX_A0)  a0_q  <= reg_wdata;
      if (reg_wen && reg_idx == IX_A1)  a1_q  <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_idx)
      IX_CTL:  reg_rdata = {{(W-CW){1'b0}}, ctl_q};
      IX_STS:  reg_rdata = {{(W-SW){1'b0}}, sts_q};
      IX_A0:   reg_rdata = a0_q;
      default: reg_rdata = a1_q;
    endcase
  end

  assign halt_req    = |hit;
  assign brk_pending = |sts_q;

  p_halt_records_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> brk_pending);
  p_mode_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1:0] == 2'b00) |-> !halt_req);
  p_inverted_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[4] && a0_q > a1_q) |-> !halt_req);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pending && !(reg_wen && reg_idx == IX_STS)) |=> brk_pending);
  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_idx == IX_STS && reg_wdata[SW-1:0] == '1 && !halt_req) |=> !brk_pending);
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[2] |-> !halt_req);
endmodule

// File: tb/test_addr_watch_unit.sv
module test_addr_watch_unit;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  reg_idx = 0;
  logic        reg_wen = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic        fetch_vld = 0, dmem_rd = 0, dmem_wr = 0;
  logic [15:0] fetch_addr = 0, dmem_addr = 0;
  logic        halt_req, brk_pending;
  int n_run = 0, n_fail = 0, cyc = 0;

  addr_watch_unit i_addr_watch_unit (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [15:0] d);
    @(negedge clk); reg_idx = idx; reg_wdata = d; reg_wen = 1;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [15:0] d);
    @(negedge clk); reg_idx = idx; #1 d = reg_rdata;
  endtask

  // kind: 0 fetch, 1 data read, 2 data write
  function automatic logic [5:0] expect_flags(input logic [4:0] c, input int kind,
      input logic [15:0] a, input logic [15:0] lo, input logic [15:0] hi);
    logic isr, isw, m0, m1, win;
    logic [5:0] e;
    isr = (kind == 0 && c[3]) || kind == 1;
    isw = kind == 2;
    m0 = a == lo; m1 = a == hi; win = a >= lo && a <= hi;
    e = 0;
    if (!c[4]) begin
      e[0] = isr & c[0] & m0; e[1] = isw & c[1] & m0;
      e[2] = isr & c[0] & m1; e[3] = isw & c[1] & m1;
    end else begin
      e[4] = isr & c[0] & win; e[5] = isw & c[1] & win;
    end
    return c[2] ? e : 6'h0;
  endfunction

  initial begin
    logic [15:0] v;
    logic [15:0] addrs [5];
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 halt", {15'h0, halt_req}, 16'h0);
    chk("R1 pending", {15'h0, brk_pending}, 16'h0);
    for (int i = 0; i < 4; i++) begin rd(i[1:0], v); chk("R1 reg", v, 16'h0); end
    // R2 readback
    wr(0, 16'hFFFF); rd(0, v); chk("R2 ctl readback", v, 16'h001F);
    wr(2, 16'hA5C3); rd(2, v); chk("R2 addr0 readback", v, 16'hA5C3);
    wr(3, 16'h5A3C); rd(3, v); chk("R2 addr1 readback", v, 16'h5A3C);

    for (int pass = 0; pass < 2; pass++) begin
      logic [15:0] lo, hi;
      lo = pass == 0 ? 16'h0040 : 16'h0048;
      hi = pass == 0 ? 16'h0048 : 16'h0040;
      addrs[0] = 16'h003F; addrs[1] = 16'h0040; addrs[2] = 16'h0044;
      addrs[3] = 16'h0048; addrs[4] = 16'h0049;
      wr(2, lo); wr(3, hi);
      for (int c = 0; c < 32; c++) begin
        wr(0, 16'(c));
        for (int k = 0; k < 3; k++) begin
          for (int ai = 0; ai < 5; ai++) begin
            logic [5:0] e;
            string tag;
            e = expect_flags(c[4:0], k, addrs[ai], lo, hi);
            tag = c[1:0] == 0 ? "R5" : (c[2] == 0 ? "R8" : (pass == 1 && c[4] ? "R7" :
                  (c[4] ? "R6" : (k == 0 ? "R4" : "R3"))));
            wr(1, 16'h003F);
            @(negedge clk);
            fetch_vld = k == 0; fetch_addr = addrs[ai];
            dmem_rd = k == 1; dmem_wr = k == 2; dmem_addr = addrs[ai];
            #2 chk({tag, " halt same cycle"}, {15'h0, halt_req}, {15'h0, |e});
            @(negedge clk);
            fetch_vld = 0; dmem_rd = 0; dmem_wr = 0;
            rd(1, v);
            chk({tag, " flags"}, v, {10'h0, e});
            chk("R10 pending", {15'h0, brk_pending}, {15'h0, |e});
          end
        end
      end
    end

    // R9 partial clear: set bits 0 and 1 then clear bit 0 only
    wr(2, 16'h0100); wr(3, 16'h0200); wr(0, 16'h0007); wr(1, 16'h003F);
    @(negedge clk); dmem_addr = 16'h0100; dmem_rd = 1;
    @(negedge clk); dmem_rd = 0; dmem_wr = 1;
    @(negedge clk); dmem_wr = 0;
    rd(1, v); chk("R9 two flags set", v, 16'h0003);
    wr(1, 16'h0001); rd(1, v); chk("R9 partial clear", v, 16'h0002);
    chk("R10 pending held", {15'h0, brk_pending}, 16'h1);
    // R9 collision: clear all while a read hit on address 1 arrives
    @(negedge clk); reg_idx = 1; reg_wdata = 16'hFFFF; reg_wen = 1;
    dmem_addr = 16'h0200; dmem_rd = 1;
    @(negedge clk); reg_wen = 0; dmem_rd = 0;
    rd(1, v); chk("R9 set beats clear", v, 16'h0004);
    // R11 upper status bits zero after writing all ones elsewhere
    chk("R11 upper zero", v & 16'hFFC0, 16'h0);
    wr(1, 16'h00FF); rd(1, v); chk("R9 clear all", v, 16'h0);
    chk("R10 pending drop", {15'h0, brk_pending}, 16'h0);
    // R3 moving address 0 to zero: read at old point no longer hits
    wr(2, 16'h0000);
    @(negedge clk); dmem_addr = 16'h0100; dmem_rd = 1; #2
    chk("R3 moved point no halt", {15'h0, halt_req}, 16'h0);
    @(negedge clk); dmem_addr = 16'h0200;  #2
    chk("R3 other point halts", {15'h0, halt_req}, 16'h1);
    @(negedge clk); dmem_rd = 0;
    rd(1, v); chk("R3 other point flag", v, 16'h0004);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule